// File: doc/BRIEF.md
# Register-Launched I2C Bus Master

This block is a bus master for a two-wire I2C bus, controlled through five byte-wide registers. Software first sets the mode register. For a write, it then loads the first outgoing byte. Writing the slave-address register launches a whole transaction. The block sends a start condition, the address byte with its direction bit, and the data bytes. It checks every acknowledge and ends with a stop condition. Software does not step through the protocol.

For writes, the block fetches each data byte from the transmit register. The transaction ends when the transmit register is empty at a byte boundary. Software keeps the transfer going by refilling that register whenever the status shows it empty. For reads, the block receives a number of bytes set by the mode register. It delivers each byte through the receive register.

Both bus lines are open-drain. The block only asserts a pull-low enable per line and watches each line through a two-flop synchronizer. The block never acts as a slave.

Top module: `i2c_reg_master`

## Requirements
- R1: While the enable bit (mode bit 7) is 0, both pull-low outputs stay 0, and a write to the slave-address register starts no transaction.
- R2: The rate field (mode bits [6:5]) sets the SCL period to 16 × 2^field core clocks (16, 32, 64 or 128). The default divider base is 16.
- R3: A transaction begins with a start condition. The first byte sent is the slave-address register itself, MSB first: the 7-bit address in bits [7:1], and the direction in bit 0 (1 = read, 0 = write).
- R4: In a write, each data byte comes from the transmit register (address 3). A byte is taken when the previous byte was acknowledged and the register is full, and taking it raises status bit 1 (transmit empty). If the register is empty at that point, the block issues a stop.
- R5: A read receives exactly count+1 bytes, where count is mode bits [4:0]. The master acknowledges every byte except the last, answers the last with NACK, and then issues a stop.
- R6: Each received byte appears in the receive register (address 4) and sets status bit 2. A read of address 4 with the read strobe clears that bit.
- R7: If the address byte is not acknowledged, the block sets status bit 3 (NACK error), sends no data byte, issues a stop and goes idle.
- R8: If a write data byte is not acknowledged, the block sets status bit 3, sends no further byte and issues a stop.
- R9: The block never drives a line high. SDA changes while SCL is released only for the start and stop conditions.
- R10: Status bit 4 (done) is set at the end of every transaction. The interrupt output is done OR NACK error. Both stay set until any write to the status register (address 2).
- R11: Register map: 0 = mode, 1 = slave address, 2 = status, 3 = transmit, 4 = receive. After reset, status reads 0x02 and both pull-low outputs are 0.
- R12: Status bit 0 (busy) is 1 from the launching address write until the stop condition completes. Only such a write with enable set raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops the receive register) |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| irq_o | output | 1 | Transaction-end interrupt |

## Verification
A behavioural open-drain slave on the bench answers three kinds of traffic:

- **Multi-byte writes**, where the bench refills the transmit register on demand. These show byte fetching and the stop-on-empty rule.
- **Reads of three bytes and of one byte.** Counting the master's ACK and NACK bits separates a correct length counter from an off-by-one counter.
- **Errors:** one address that is refused, and a write where the second data byte is refused. These show that a NACK stops the transfer instead of continuing it.

The SCL period is measured at three rate codes. Start and stop conditions seen on the bus are counted against the number of transactions, so any SDA change while SCL is high shows up as an extra start or stop.

// File: rtl/i2cm_pkg.sv
// Shared types and constants for the register-launched I2C master.
// Assumes a 3-bit register select and an 8-bit data path.
package i2cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_ACK,
        ST_STOP
    } seq_state_t;

    localparam logic [2:0] REG_MODE  = 3'd0;
    localparam logic [2:0] REG_SLAVE = 3'd1;
    localparam logic [2:0] REG_STAT  = 3'd2;
    localparam logic [2:0] REG_TXD   = 3'd3;
    localparam logic [2:0] REG_RXD   = 3'd4;

    localparam int MODE_EN_BIT = 7;
    localparam int CNT_W       = 5;
endpackage

// File: rtl/i2cm_sync.sv
// Two-flop synchronizer for the sampled bus lines.
// Assumes lines idle high, so reset value is 1.
module i2cm_sync #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // two-stage resampling of the asynchronous line levels
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '1;
            q_o    <= '1;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/i2cm_tick.sv
// Quarter-bit tick generator: one tick every (DIV_BASE/4) << rate clocks.
// Assumes DIV_BASE is a multiple of 4; counter is held at zero while idle.
module i2cm_tick #(
    parameter int DIV_BASE = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int QBASE = DIV_BASE / 4;
    localparam int CW    = $clog2(QBASE * 8) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last   = (CW'(QBASE) << rate_i) - CW'(1);
    assign tick_o = run_i && (cnt_q == last);

    // free-running quarter counter while a transaction is active
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) cnt_q <= '0;
        else if (tick_o)       cnt_q <= '0;
        else                   cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/i2cm_seq.sv
// Byte sequencer: start, address, data/ack slots, stop.
// Each slot is four quarter ticks; SCL is low in quarters 0-1 and released in 2-3.
// SDA changes only on entry to quarter 1 (SCL low), except inside START/STOP.
// Assumes no clock stretching and sampled inputs that are already synchronized.
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int LW = CNT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          launch_i,
    input  logic [7:0]    addr_byte_i,
    input  logic [LW-1:0] rd_last_i,
    input  logic          tick_i,
    input  logic          scl_rise_i,
    input  logic          sda_in_i,
    input  logic          bus_idle_i,
    input  logic [7:0]    tx_byte_i,
    input  logic          tx_full_i,
    output logic          tx_take_o,
    output logic [7:0]    rx_byte_o,
    output logic          rx_strobe_o,
    output logic          nack_o,
    output logic          done_o,
    output logic          busy_o,
    output logic          scl_lo_o,
    output logic          sda_lo_o,
    output seq_state_t    state_o
);
    seq_state_t    st_q;
    logic [1:0]    qtr_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          addr_ph_q;
    logic          rd_q;
    logic [LW-1:0] left_q;
    logic          samp_q;
    logic          sda_lo_q;

    logic slot_end, hold, rd_data, chk_ack;

    assign rd_data  = rd_q && !addr_ph_q;
    assign chk_ack  = (st_q == ST_ACK) && !rd_data;
    assign hold     = (st_q == ST_START) && (qtr_q == 2'd0) && !bus_idle_i;
    assign slot_end = tick_i && !hold && (qtr_q == 2'd3);

    assign tx_take_o   = slot_end && chk_ack && !samp_q && !rd_q && tx_full_i;
    assign nack_o      = slot_end && chk_ack && samp_q;
    assign rx_strobe_o = slot_end && (st_q == ST_SHIFT) && rd_data && (bit_q == 3'd0);
    assign rx_byte_o   = {sh_q[6:0], samp_q};
    assign done_o      = slot_end && (st_q == ST_STOP);
    assign busy_o      = (st_q != ST_IDLE);
    assign sda_lo_o    = sda_lo_q;
    assign state_o     = st_q;

    // SCL pull-low pattern per state and quarter
    always_comb begin
        case (st_q)
            ST_START:                 scl_lo_o = qtr_q[1];
            ST_SHIFT, ST_ACK, ST_STOP: scl_lo_o = !qtr_q[1];
            default:                  scl_lo_o = 1'b0;
        endcase
    end

    // sequencer state, shift register and SDA drive
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= ST_IDLE;
            qtr_q     <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            addr_ph_q <= 1'b0;
            rd_q      <= 1'b0;
            left_q    <= '0;
            samp_q    <= 1'b1;
            sda_lo_q  <= 1'b0;
        end else if (!en_i) begin
            st_q     <= ST_IDLE;
            qtr_q    <= '0;
            sda_lo_q <= 1'b0;
        end else begin
            if (scl_rise_i) samp_q <= sda_in_i;
            if (st_q == ST_IDLE) begin
                sda_lo_q <= 1'b0;
                if (launch_i) begin
                    st_q      <= ST_START;
                    qtr_q     <= '0;
                    sh_q      <= addr_byte_i;
                    rd_q      <= addr_byte_i[0];
                    addr_ph_q <= 1'b1;
                    left_q    <= rd_last_i;
                end
            end else if (tick_i && !hold) begin
                qtr_q <= qtr_q + 2'd1;
                if (qtr_q == 2'd0) begin
                    case (st_q)
                        ST_START: sda_lo_q <= 1'b1;
                        ST_SHIFT: sda_lo_q <= rd_data ? 1'b0 : !sh_q[7];
                        ST_ACK:   sda_lo_q <= rd_data && (left_q != '0);
                        ST_STOP:  sda_lo_q <= 1'b1;
                        default:  sda_lo_q <= 1'b0;
                    endcase
                end
                if (qtr_q == 2'd2 && st_q == ST_STOP) sda_lo_q <= 1'b0;
                if (qtr_q == 2'd3) begin
                    case (st_q)
                        ST_START: begin
                            st_q  <= ST_SHIFT;
                            bit_q <= 3'd7;
                        end
                        ST_SHIFT: begin
                            sh_q <= {sh_q[6:0], samp_q};
                            if (bit_q == 3'd0) st_q <= ST_ACK;
                            else               bit_q <= bit_q - 3'd1;
                        end
                        ST_ACK: begin
                            bit_q <= 3'd7;
                            if (chk_ack) begin
                                if (samp_q) begin
                                    st_q <= ST_STOP;
                                end else if (rd_q) begin
                                    addr_ph_q <= 1'b0;
                                    st_q      <= ST_SHIFT;
                                end else if (tx_full_i) begin
                                    addr_ph_q <= 1'b0;
                                    sh_q      <= tx_byte_i;
                                    st_q      <= ST_SHIFT;
                                end else begin
                                    st_q <= ST_STOP;
                                end
                            end else if (left_q == '0) begin
                                st_q <= ST_STOP;
                            end else begin
                                left_q <= left_q - LW'(1);
                                st_q   <= ST_SHIFT;
                            end
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/i2c_reg_master.sv
// Register-launched I2C master top: register bank, synchronizers, divider, sequencer.
// Assumes a single register access per cycle; reads return the selected register combinationally.
module i2c_reg_master
    import i2cm_pkg::*;
#(
    parameter int DIV_BASE = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       reg_wr_i,
    input  logic       reg_rd_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       irq_o
);
    logic [7:0] mode_q, slave_q, tx_q, rx_q;
    logic       tx_full_q, rx_valid_q, nack_q, done_q;
    logic [1:0] lines_s;
    logic       scl_s_d;
    logic       tick, launch, busy, scl_lo, sda_lo;
    logic       tx_take, rx_strobe, nack_p, done_p;
    logic [7:0] rx_byte;
    logic [7:0] status;
    seq_state_t seq_st;

    assign launch = reg_wr_i && (reg_addr_i == REG_SLAVE) && mode_q[MODE_EN_BIT] && !busy;
    assign status = {3'b000, done_q, nack_q, rx_valid_q, !tx_full_q, busy};

    i2cm_sync #(.W(2)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    i2cm_tick #(.DIV_BASE(DIV_BASE)) u_tick (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (busy),
        .rate_i(mode_q[6:5]),
        .tick_o(tick)
    );

    i2cm_seq #(.LW(CNT_W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (mode_q[MODE_EN_BIT]),
        .launch_i   (launch),
        .addr_byte_i(reg_wdata_i),
        .rd_last_i  (mode_q[CNT_W-1:0]),
        .tick_i     (tick),
        .scl_rise_i (lines_s[1] && !scl_s_d),
        .sda_in_i   (lines_s[0]),
        .bus_idle_i (&lines_s),
        .tx_byte_i  (tx_q),
        .tx_full_i  (tx_full_q),
        .tx_take_o  (tx_take),
        .rx_byte_o  (rx_byte),
        .rx_strobe_o(rx_strobe),
        .nack_o     (nack_p),
        .done_o     (done_p),
        .busy_o     (busy),
        .scl_lo_o   (scl_lo),
        .sda_lo_o   (sda_lo),
        .state_o    (seq_st)
    );

    // register bank and sticky status flags
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q     <= '0;
            slave_q    <= '0;
            tx_q       <= '0;
            rx_q       <= '0;
            tx_full_q  <= 1'b0;
            rx_valid_q <= 1'b0;
            nack_q     <= 1'b0;
            done_q     <= 1'b0;
            scl_s_d    <= 1'b1;
        end else begin
            scl_s_d <= lines_s[1];
            if (reg_wr_i && reg_addr_i == REG_MODE) mode_q <= reg_wdata_i;
            if (launch) slave_q <= reg_wdata_i;
            if (reg_wr_i && reg_addr_i == REG_TXD) begin
                tx_q      <= reg_wdata_i;
                tx_full_q <= 1'b1;
            end else if (tx_take) begin
                tx_full_q <= 1'b0;
            end
            if (rx_strobe) begin
                rx_q       <= rx_byte;
                rx_valid_q <= 1'b1;
            end else if (reg_rd_i && reg_addr_i == REG_RXD) begin
                rx_valid_q <= 1'b0;
            end
            if (reg_wr_i && reg_addr_i == REG_STAT) begin
                nack_q <= 1'b0;
                done_q <= 1'b0;
            end else begin
                if (nack_p) nack_q <= 1'b1;
                if (done_p) done_q <= 1'b1;
            end
        end
    end

    // read-data multiplexer
    always_comb begin
        case (reg_addr_i)
            REG_MODE:  reg_rdata_o = mode_q;
            REG_SLAVE: reg_rdata_o = slave_q;
            REG_STAT:  reg_rdata_o = status;
            REG_TXD:   reg_rdata_o = tx_q;
            REG_RXD:   reg_rdata_o = rx_q;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign scl_oe_o = mode_q[MODE_EN_BIT] && scl_lo;
    assign sda_oe_o = mode_q[MODE_EN_BIT] && sda_lo;
    assign irq_o    = done_q || nack_q;
endmodule

// File: rtl/i2cm_checker.sv
// Protocol checker for i2c_reg_master, attached by bind below.
// Assumes the top's internal names mode_q, busy, seq_st and rx_strobe.
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       reg_wr_i,
    input logic [2:0] reg_addr_i,
    input logic [7:0] mode,
    input logic       busy,
    input seq_state_t st,
    input logic       rx_strobe,
    input logic       scl_oe_o,
    input logic       sda_oe_o,
    input logic       irq_o
);
    logic [5:0] rx_cnt_q;

    // bytes received in the current transaction
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !busy) rx_cnt_q <= '0;
        else if (rx_strobe)   rx_cnt_q <= rx_cnt_q + 6'd1;
    end

    assert_no_launch_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == REG_SLAVE && !mode[MODE_EN_BIT] && !busy) |=> !busy);

    assert_read_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_strobe |-> (rx_cnt_q <= {1'b0, mode[CNT_W-1:0]}));

    assert_sda_stable_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o))
         && mode[MODE_EN_BIT] && $past(mode[MODE_EN_BIT]))
        |-> (st == ST_START || st == ST_STOP));

    assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(reg_wr_i && reg_addr_i == REG_STAT));

    assert_busy_from_launch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(reg_wr_i && reg_addr_i == REG_SLAVE && mode[MODE_EN_BIT]));
endmodule

bind i2c_reg_master i2cm_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reg_wr_i  (reg_wr_i),
    .reg_addr_i(reg_addr_i),
    .mode      (mode_q),
    .busy      (busy),
    .st        (seq_st),
    .rx_strobe (rx_strobe),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .irq_o     (irq_o)
);

// File: tb/test_i2c_reg_master.sv
// Scoreboard bench: driver tasks queue expected bytes, a bus-level slave
// model and the read path pop and compare them as bytes appear.
module test_i2c_reg_master;
    localparam logic [6:0] SLV = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       slv_pull = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | slv_pull);

    int checks = 0, fails = 0, cyc = 0;
    int last_rise = 0, last_period = 0;
    logic prev_scl_oe = 1'b0;
    logic [7:0] exp_wr[$];
    logic [7:0] exp_rd[$];

    // slave model state
    int s_phase = 0, s_bit = 0, s_wr_idx = 0, s_rd_idx = 0, nack_at = -1;
    int n_start = 0, n_stop = 0, wr_cnt = 0, ack_cnt = 0, nack_cnt = 0;
    logic [7:0] s_sh = '0, s_out = '0, s_addr_seen = '0;
    logic s_rw = 1'b0, s_ack = 1'b0, m_ack = 1'b0;

    i2c_reg_master i_i2c_reg_master (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .reg_wr_i   (reg_wr),
        .reg_rd_i   (reg_rd),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .scl_i      (scl_line),
        .sda_i      (sda_line),
        .scl_oe_o   (scl_oe),
        .sda_oe_o   (sda_oe),
        .irq_o      (irq)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // SCL period monitor
    always @(posedge clk) begin
        cyc++;
        if (scl_oe && !prev_scl_oe) begin
            last_period = cyc - last_rise;
            last_rise   = cyc;
        end
        prev_scl_oe = scl_oe;
    end

    // slave: start and stop detection
    always @(negedge sda_line) if (scl_line === 1'b1 && rst_n) begin
        n_start++; s_phase = 1; s_bit = 0; s_wr_idx = 0; slv_pull = 1'b0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1 && rst_n) begin
        n_stop++; s_phase = 0; slv_pull = 1'b0;
    end

    // slave: sample on SCL rise
    always @(posedge scl_line) if (s_phase != 0) begin
        if (s_bit < 8) begin
            if (s_phase != 3) s_sh = {s_sh[6:0], sda_line};
        end else if (s_phase == 3) begin
            m_ack = ~sda_line;
        end
        s_bit++;
    end

    // slave: drive on SCL fall; compares written bytes against the scoreboard
    always @(negedge scl_line) if (s_phase != 0) begin
        if (s_bit == 8) begin
            if (s_phase == 1) begin
                s_addr_seen = s_sh; s_rw = s_sh[0]; s_ack = (s_sh[7:1] == SLV);
            end else if (s_phase == 2) begin
                wr_cnt++;
                if (exp_wr.size() == 0) check(1'b0, "R4 unexpected write byte", s_sh, 0);
                else begin
                    logic [7:0] e;
                    e = exp_wr.pop_front();
                    check(s_sh == e, "R4 write byte", s_sh, e);
                end
                s_ack = (s_wr_idx != nack_at);
                s_wr_idx++;
            end else s_ack = 1'b0;
            slv_pull = (s_phase != 3) && s_ack;
        end else if (s_bit == 9) begin
            s_bit = 0; slv_pull = 1'b0;
            if (s_phase == 1) begin
                if (!s_ack) s_phase = 0;
                else if (s_rw) begin s_phase = 3; s_rd_idx = 0; s_out = 8'hC0; end
                else s_phase = 2;
            end else if (s_phase == 2) begin
                if (!s_ack) s_phase = 0;
            end else if (m_ack) begin
                ack_cnt++; s_rd_idx++; s_out = 8'hC0 + 8'(s_rd_idx);
            end else begin
                nack_cnt++; s_phase = 0;
            end
            if (s_phase == 3) slv_pull = ~s_out[7];
        end else if (s_phase == 3) begin
            slv_pull = ~s_out[7 - s_bit];
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic pop, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = pop; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_stat(input int bitn, input string req);
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd2, 1'b0, s);
            if (s[bitn]) return;
        end
        check(1'b0, req, 0, 1);
    endtask

    task automatic read_bytes(input int n);
        logic [7:0] d, e;
        for (int i = 0; i < n; i++) begin
            wait_stat(2, "R6 rx valid timeout");
            rd(3'd4, 1'b1, d);
            e = (exp_rd.size() != 0) ? exp_rd.pop_front() : 8'hxx;
            check(d === e, "R6 received byte", d, e);
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd(3'd2, 1'b0, s);
        check(s == 8'h02, "R11 reset status", s, 8'h02);
        check(!scl_oe && !sda_oe && !irq, "R11 reset outputs", {scl_oe, sda_oe, irq}, 0);

        // R1: disabled block ignores launch
        wr(3'd0, 8'h00);
        wr(3'd1, {SLV, 1'b0});
        repeat (300) @(negedge clk);
        rd(3'd2, 1'b0, s);
        check(s[0] == 1'b0, "R1 no busy when disabled", s, 8'h02);
        check(n_start == 0 && !scl_oe && !sda_oe, "R1 bus untouched", n_start, 0);

        // R3 R4 R2 R12: two-byte write at rate 0
        wr(3'd0, 8'h80);
        wr(3'd3, 8'hA5); exp_wr.push_back(8'hA5);
        wr(3'd1, {SLV, 1'b0});
        rd(3'd2, 1'b0, s);
        check(s[0] == 1'b1, "R12 busy after launch", s[0], 1);
        wait_stat(1, "R4 tx empty timeout");
        wr(3'd3, 8'h3C); exp_wr.push_back(8'h3C);
        wait_stat(4, "R10 done timeout");
        check(s_addr_seen == {SLV, 1'b0}, "R3 address byte", s_addr_seen, {SLV, 1'b0});
        check(wr_cnt == 2 && exp_wr.size() == 0, "R4 bytes written then stop", wr_cnt, 2);
        check(last_period == 16, "R2 SCL period rate 0", last_period, 16);
        rd(3'd2, 1'b0, s);
        check(s == 8'h12, "R12 idle with done, no error", s, 8'h12);

        // R10: sticky interrupt, cleared by status write
        repeat (50) @(negedge clk);
        check(irq == 1'b1, "R10 irq held", irq, 1);
        wr(3'd2, 8'h00);
        rd(3'd2, 1'b0, s);
        check(!irq && s[4] == 1'b0, "R10 irq cleared", {irq, s[4]}, 0);

        // R5 R6 R2: three-byte read at rate 1
        ack_cnt = 0; nack_cnt = 0;
        wr(3'd0, 8'hA2);
        for (int i = 0; i < 3; i++) exp_rd.push_back(8'hC0 + 8'(i));
        wr(3'd1, {SLV, 1'b1});
        read_bytes(3);
        wait_stat(4, "R10 done timeout");
        check(ack_cnt == 2 && nack_cnt == 1, "R5 ack pattern 3 bytes", ack_cnt * 16 + nack_cnt, 8'h21);
        check(last_period == 32, "R2 SCL period rate 1", last_period, 32);
        rd(3'd2, 1'b0, s);
        check(s[2] == 1'b0 && s[3] == 1'b0, "R6 rx valid cleared by read", s, 8'h12);
        wr(3'd2, 8'h00);

        // R5 R2: single-byte read at rate 3
        ack_cnt = 0; nack_cnt = 0;
        wr(3'd0, 8'hE0);
        exp_rd.push_back(8'hC0);
        wr(3'd1, {SLV, 1'b1});
        read_bytes(1);
        wait_stat(4, "R10 done timeout");
        check(ack_cnt == 0 && nack_cnt == 1, "R5 ack pattern 1 byte", ack_cnt * 16 + nack_cnt, 1);
        check(last_period == 128, "R2 SCL period rate 3", last_period, 128);
        wr(3'd2, 8'h00);

        // R7: address refused
        wr_cnt = 0;
        wr(3'd0, 8'h80);
        wr(3'd3, 8'h11);
        wr(3'd1, 8'h44);
        wait_stat(4, "R10 done timeout");
        rd(3'd2, 1'b0, s);
        check(s[3] == 1'b1 && s[0] == 1'b0, "R7 nack flag, idle", s, 8'h18);
        check(wr_cnt == 0 && s[1] == 1'b0, "R7 no data byte sent", wr_cnt, 0);
        check(irq == 1'b1, "R10 irq on error", irq, 1);
        wr(3'd2, 8'h00);

        // R8: second write byte refused
        wr_cnt = 0; nack_at = 1;
        wr(3'd3, 8'h21); exp_wr.push_back(8'h21);
        wr(3'd1, {SLV, 1'b0});
        wait_stat(1, "R4 tx empty timeout");
        wr(3'd3, 8'h22); exp_wr.push_back(8'h22);
        wait_stat(1, "R4 tx empty timeout");
        wr(3'd3, 8'h23);
        wait_stat(4, "R10 done timeout");
        rd(3'd2, 1'b0, s);
        check(s[3] == 1'b1, "R8 nack flag on data", s, 8'h18);
        check(wr_cnt == 2 && s[1] == 1'b0, "R8 transfer stopped", wr_cnt, 2);
        wr(3'd2, 8'h00);
        nack_at = -1;

        // R9: only one start and one stop per transaction
        check(n_start == 5 && n_stop == 5, "R9 start/stop count", n_start * 256 + n_stop, 5 * 256 + 5);
        check(exp_wr.size() == 0 && exp_rd.size() == 0, "R4 scoreboard drained", exp_wr.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule